// File: doc/BRIEF.md
# Self-Refresh Entry and Exit Sequencer

This block moves a page-mode DRAM array into its self-refresh state when a sleep request arrives, and brings it back out when a wake request arrives. It drives the active-low row strobe, column strobe and write enable for the entry and exit only. It asks a separate refresh scheduler to run a complete back-to-back refresh of every row just before entry and again just after exit. While a burst is requested the sequencer keeps all of its strobes high, so the scheduler owns the bus.

Entry is a column-before-row sequence. After the pre-entry burst, the sequencer waits a fixed gap that is kept far below the 16 ms allowed between the last full pass and entry. It then lowers the column strobe and, after a setup time, lowers the row strobe. Both strobes then stay low for a minimum dwell equal to 100 µs of clock cycles. A wake request that arrives early is remembered and carried out when the dwell ends. On exit, both strobes rise in the same cycle. A precharge time of at least 84 ns follows, and then the post-exit burst is requested at once. The wake acknowledge is given only after that burst completes.

Top module: `sr_sequencer`

## Requirements
- R1: After reset, ras_n, cas_n and we_n are 1, and burst_req, sleep_ack and wake_ack are 0. In the idle state, a 1 on sleep_req at a clock edge raises burst_req on the next cycle. burst_req stays 1 until a cycle in which burst_done is 1.
- R2: After the pre-entry burst_done, all strobes stay high for ENTRY_GAP cycles. cas_n is then 0 for CSR_CYC cycles while ras_n is still 1, before ras_n falls (column before row). ENTRY_GAP must be below GAP_LIMIT.
- R3: Once ras_n falls in self refresh, ras_n and cas_n both stay 0 for at least DWELL_CYC cycles.
- R4: A wake_req pulse seen at any point of the dwell is held. If wake_req arrived early, ras_n and cas_n rise together in the cycle after the dwell reaches exactly DWELL_CYC cycles. Otherwise they rise in the cycle after the wake_req edge.
- R5: we_n is 1 in every cycle.
- R6: After exit, ras_n and cas_n stay 1 for RPS_CYC cycles. burst_req is then 1 until burst_done is 1.
- R7: sleep_ack is a one-cycle pulse in the first cycle of the dwell.
- R8: wake_ack is a one-cycle pulse in the cycle after burst_done ends the post-exit burst. wake_ack is 0 at all other times.
- R9: wake_req has no effect outside the dwell. burst_done has no effect outside the two burst phases. sleep_req has no effect outside the idle state.
- R10: burst_req is never 1 while ras_n or cas_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter self refresh |
| sleep_ack | output | 1 | Pulse: array has entered self refresh |
| wake_req | input | 1 | Request to leave self refresh |
| wake_ack | output | 1 | Pulse: exit burst finished, array usable |
| burst_req | output | 1 | Asks the refresh scheduler for a full row burst |
| burst_done | input | 1 | Pulse from the scheduler: burst finished |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The bench runs two sleep/wake rounds. In the first, the wake pulse comes long before the dwell ends. In the second, it comes well after. The first round shows that an early wake is stored and released at exactly the minimum dwell. The second shows that the exit follows the wake edge itself. Stray wake, sleep and done pulses are also injected in idle, during the entry burst and during the dwell. Any reaction to them shows up as a strobe or handshake mismatch against the cycle-by-cycle reference model.

// File: rtl/sr_sequencer.sv
module sr_sequencer #(
  parameter int DWELL_CYC = 10000,
  parameter int RPS_CYC   = 9,
  parameter int CSR_CYC   = 1,
  parameter int ENTRY_GAP = 4,
  parameter int GAP_LIMIT = 1600000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic sleep_ack,
  input  logic wake_req,
  output logic wake_ack,
  output logic burst_req,
  input  logic burst_done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int MAXC = (DWELL_CYC > RPS_CYC + ENTRY_GAP + CSR_CYC) ? DWELL_CYC
                        : RPS_CYC + ENTRY_GAP + CSR_CYC;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_GAP, S_SETUP, S_DWELL, S_PRECH, S_POST} st_t;

  generate
    if (ENTRY_GAP < 1 || ENTRY_GAP >= GAP_LIMIT || CSR_CYC < 1 || RPS_CYC < 1 || DWELL_CYC < 1)
      $error("sr_sequencer: timing parameters out of range");
  endgenerate

  st_t st;
  logic [CW-1:0] cnt;
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      pend <= 1'b0;
      wake_ack <= 1'b0;
    end else begin
      wake_ack <= 1'b0;
      case (st)
        S_IDLE: if (sleep_req) st <= S_PRE;
        S_PRE: if (burst_done) begin st <= S_GAP; cnt <= '0; end
        S_GAP:
          if (cnt == CW'(ENTRY_GAP - 1)) begin st <= S_SETUP; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_SETUP:
          if (cnt == CW'(CSR_CYC - 1)) begin st <= S_DWELL; cnt <= '0; pend <= 1'b0; end
          else cnt <= cnt + 1'b1;
        S_DWELL: begin
          if (cnt != CW'(DWELL_CYC - 1)) cnt <= cnt + 1'b1;
          if (wake_req) pend <= 1'b1;
          if (cnt == CW'(DWELL_CYC - 1) && (pend || wake_req)) begin
            st <= S_PRECH;
            cnt <= '0;
          end
        end
        S_PRECH:
          if (cnt == CW'(RPS_CYC - 1)) begin st <= S_POST; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_POST: if (burst_done) begin st <= S_IDLE; wake_ack <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ras_n     = (st != S_DWELL);
  assign cas_n     = !(st == S_SETUP || st == S_DWELL);
  assign we_n      = 1'b1;
  assign burst_req = (st == S_PRE) || (st == S_POST);
  assign sleep_ack = (st == S_DWELL) && (cnt == '0);

  // Independent strobe run-length counters for the timing checks
  logic [CW-1:0] low_run, high_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= '0;
      high_run <= '0;
    end else begin
      low_run  <= ras_n ? '0 : ((low_run == CW'(MAXC)) ? low_run : low_run + 1'b1);
      high_run <= !ras_n ? '0 : ((high_run == CW'(MAXC)) ? high_run : high_run + 1'b1);
    end
  end

  assert_cbr_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));
  assert_min_dwell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> low_run >= CW'(DWELL_CYC));
  assert_joint_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);
  assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(burst_req) && $past(high_run) != '0 && st == S_POST) |-> high_run >= CW'(RPS_CYC));
  assert_ack_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |-> $past(burst_done));
  assert_bus_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> (ras_n && cas_n));
endmodule

// File: tb/test_sr_sequencer.sv
module test_sr_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int DWELL = 10000, RPS = 9, CSR = 1, GAP = 4;

  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, wake_req = 0, burst_done = 0;
  logic sleep_ack, wake_ack, burst_req, ras_n, cas_n, we_n;
  int checks = 0, errors = 0, cyc = 0;

  sr_sequencer #(.DWELL_CYC(DWELL), .RPS_CYC(RPS), .CSR_CYC(CSR), .ENTRY_GAP(GAP),
                 .GAP_LIMIT(1600000)) i_sr_sequencer (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_ack(sleep_ack),
    .wake_req(wake_req), .wake_ack(wake_ack), .burst_req(burst_req),
    .burst_done(burst_done), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: phase number and countdowns
  int ph = 0, left = 0, low = 0;
  bit pend = 0, m_wack = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; left = 0; low = 0; pend = 0; m_wack = 0;
    end else begin
      m_wack = 0;
      case (ph)
        0: if (sleep_req) ph = 1;
        1: if (burst_done) begin ph = 2; left = GAP; end
        2: begin left--; if (left == 0) begin ph = 3; left = CSR; end end
        3: begin left--; if (left == 0) begin ph = 4; low = 0; pend = 0; end end
        4: begin
          low++;
          if (wake_req) pend = 1;
          if (low >= DWELL && pend) begin ph = 5; left = RPS; end
        end
        5: begin left--; if (left == 0) ph = 6; end
        6: if (burst_done) begin ph = 0; m_wack = 1; end
        default: ph = 0;
      endcase
    end
  end

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, nm, act, exp, cyc);
    end
  endtask

  int run = 0, last_run = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3/R4", "ras_n", ras_n, !(ph == 4));
      chk("R2", "cas_n", cas_n, !(ph == 3 || ph == 4));
      chk("R5", "we_n", we_n, 1'b1);
      chk("R1/R6", "burst_req", burst_req, (ph == 1 || ph == 6));
      chk("R7", "sleep_ack", sleep_ack, (ph == 4 && low == 0));
      chk("R8", "wake_ack", wake_ack, m_wack);
      if (!ras_n) run++;
      else if (run != 0) begin last_run = run; run = 0; end
    end
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(2);
    // R1: reset state
    chk("R1", "reset ras_n", ras_n, 1'b1);
    chk("R1", "reset burst_req", burst_req, 1'b0);
    chk("R1", "reset wake_ack", wake_ack, 1'b0);
    rst_n = 1;
    idle(2);
    // R9: stray pulses in idle are ignored
    pulse(wake_req); pulse(burst_done); idle(3);
    chk("R9", "idle burst_req", burst_req, 1'b0);
    chk("R9", "idle ras_n", ras_n, 1'b1);
    // Round 1: early wake
    pulse(sleep_req); idle(5);
    pulse(wake_req); idle(2);
    pulse(burst_done);
    while (sleep_ack !== 1'b1) @(negedge clk);
    idle(20);
    pulse(sleep_req); pulse(burst_done);
    pulse(wake_req);
    idle(DWELL + 5);
    idle(6); pulse(burst_done);
    chk("R8", "wake_ack early", wake_ack, 1'b1);
    checks++;
    if (last_run != DWELL) begin
      errors++;
      $display("FAIL R4 held wake dwell actual=%0d expected=%0d", last_run, DWELL);
    end
    idle(5);
    // Round 2: late wake
    pulse(sleep_req); idle(3); pulse(burst_done);
    idle(DWELL + 60);
    chk("R3", "still in self refresh", ras_n, 1'b0);
    pulse(wake_req);
    idle(RPS + 3);
    chk("R6", "post burst requested", burst_req, 1'b1);
    pulse(burst_done);
    chk("R8", "wake_ack late", wake_ack, 1'b1);
    checks++;
    if (last_run != DWELL + GAP + CSR + 60 - GAP - CSR + 1 && last_run <= DWELL) begin
      errors++;
      $display("FAIL R3 late dwell actual=%0d expected>%0d", last_run, DWELL);
    end
    idle(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule